// File: doc/BRIEF.md
# Lockable Set-Associative Instruction Cache

This block is a read-only instruction cache that sits between an instruction fetch unit and external memory. Each set holds many ways of 32-byte lines (eight 32-bit words). A fetch presents a word address and is answered with one instruction word together with a flag that tells whether the word came from the cache. When a fetch misses, the cache issues one whole-line read to external memory. The memory returns the requested word first and then the rest of the line in wrapping order. The fetch is answered as soon as that first word arrives, and the line is installed once all eight beats are in. A per-request flag marks an address as non-cacheable. Such an access becomes a single-word external read and does not allocate a line.

A control port offers two commands. The first invalidates the whole cache, which also clears every lock. The second is fetch-and-lock: it pins a line so that replacement never evicts it. If the line is not present, the command loads it first. Victims are chosen round-robin among the unlocked ways of a set. A set may hold at most one fewer locked lines than it has ways, and a lock request past that limit is refused with an error pulse. The number of ways and the number of sets are parameters. The default geometry is 32 ways by 32 sets, which gives 32 KB.

All addresses on the ports are word addresses (byte address divided by four). Word address bits [2:0] select the word in a line, the next log2(SETS) bits select the set, and the remaining upper bits form the tag.

Top module: `icache_lockable`

## Requirements
- R1: After reset no line is valid and no line is locked. `c_busy`, `f_done`, `c_err` and `m_req` are all low.
- R2: A cacheable fetch that misses raises `m_req` for exactly one cycle with `m_single`=0. `m_waddr` equals the requested word address. The cache then accepts eight `m_rvalid` beats, whose word offsets are (requested offset + beat number) modulo 8.
- R3: A missing fetch is answered with `f_done`=1 and `f_hit`=0 in the cycle after the first refill beat, before the remaining beats arrive. `f_data` equals that beat's data.
- R4: A fetch that hits is answered two clock cycles after `f_req` is first seen while idle, with `f_hit`=1 and the stored word, and it raises no `m_req`.
- R5: A fetch with `f_nc`=1 raises `m_req` with `m_single`=1, waits for one beat and returns it with `f_hit`=0. No line is allocated, so a later cacheable fetch of the same address misses.
- R6: On a miss, the victim is the first unlocked way found by scanning upward, with wrap-around, from the set's round-robin pointer. After the fill, the pointer moves to the way after the victim.
- R7: A locked line is never chosen as a victim and keeps hitting however many other lines map to its set.
- R8: `c_lock` with `c_waddr` locks the line in place if it is present, with no memory read. If the line is absent, one line read loads it straight into a locked way. Locking a line that is already locked is a no-op. `c_busy` stays high until the command has finished.
- R9: At most WAYS-1 lines per set can be locked. A lock request that would exceed this pulses `c_err`, issues no memory read and changes no lock bit.
- R10: `c_inv` clears every valid bit and every lock bit, one set per cycle. `c_busy` is high for exactly SETS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_req | input | 1 | Fetch request, held until `f_done` |
| f_nc | input | 1 | Request is non-cacheable |
| f_waddr | input | ADDR_W-2 | Fetch word address |
| f_done | output | 1 | One-cycle pulse: `f_data` is valid |
| f_hit | output | 1 | Answer came from the cache |
| f_data | output | 32 | Instruction word |
| c_inv | input | 1 | Invalidate-all command (sampled while idle) |
| c_lock | input | 1 | Fetch-and-lock command (sampled while idle) |
| c_waddr | input | ADDR_W-2 | Word address for the lock command |
| c_busy | output | 1 | A fetch or command is in progress |
| c_err | output | 1 | One-cycle pulse: lock refused |
| m_req | output | 1 | One-cycle external read request |
| m_single | output | 1 | 1: one-word read, 0: eight-beat line read |
| m_waddr | output | ADDR_W-2 | Word address of the first beat wanted |
| m_rvalid | input | 1 | Read beat valid |
| m_rdata | input | 32 | Read beat data |

## Verification
The bench builds the cache with 4 ways and 4 sets. With this geometry, filling a set and then overflowing it takes only five misses, so round-robin eviction and the protection of locked lines can be observed directly through hit and miss answers. The lock limit of three is reached after three commands, and the refusal is checked both for an absent line and for a line that is already present. With four sets, an invalidate lasts four cycles, so the busy window can be counted exactly. The memory model leaves a gap between beats, which makes it visible that the early answer arrives after the first beat rather than after the whole line.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int LINE_WORDS = 8;
    localparam int WORD_W     = 32;
    localparam int LINE_W     = LINE_WORDS * WORD_W;
    localparam int WOFF_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOOK = 3'd1,
        ST_FILL = 3'd2,
        ST_NCRD = 3'd3,
        ST_INV  = 3'd4
    } ic_state_e;
endpackage

// File: rtl/icache_way_match.sv
module icache_way_match #(
    parameter int WAYS  = 32,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit_any,
    output logic [WAY_W-1:0]           hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = set_vld[g] && (set_tags[g] == probe_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/icache_victim.sv
module icache_victim #(
    parameter int WAYS = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  locked,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] victim
);
    always_comb begin
        logic             found;
        logic [WAY_W-1:0] cand;
        victim = ptr;
        found  = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            cand = ptr + WAY_W'(i);
            if (!found && !locked[cand]) begin
                victim = cand;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/icache_lockable.sv
module icache_lockable
    import icache_pkg::*;
#(
    parameter int WAYS   = 32,
    parameter int SETS   = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_req,
    input  logic              f_nc,
    input  logic [ADDR_W-3:0] f_waddr,
    output logic              f_done,
    output logic              f_hit,
    output logic [31:0]       f_data,
    input  logic              c_inv,
    input  logic              c_lock,
    input  logic [ADDR_W-3:0] c_waddr,
    output logic              c_busy,
    output logic              c_err,
    output logic              m_req,
    output logic              m_single,
    output logic [ADDR_W-3:0] m_waddr,
    input  logic              m_rvalid,
    input  logic [31:0]       m_rdata
);
    localparam int WA_W     = ADDR_W - 2;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int SET_W    = $clog2(SETS);
    localparam int TAG_W    = WA_W - WOFF_W - SET_W;
    localparam int LOCK_MAX = WAYS - 1;
    localparam int ENTRIES  = SETS * WAYS;

    typedef struct packed {
        ic_state_e          st;
        logic [WA_W-1:0]    waddr;
        logic               nc;
        logic               lockop;
        logic [WOFF_W-1:0]  beat;
        logic [SET_W-1:0]   inv_set;
        logic [WAY_W-1:0]   vic;
        logic [LINE_W-1:0]  lbuf;
        logic               f_done;
        logic               f_hit;
        logic [WORD_W-1:0]  f_data;
        logic               c_err;
        logic               m_req;
    } regs_t;

    regs_t r_q, r_d;

    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    logic [LINE_W-1:0] line_q [ENTRIES];
    logic [WAYS-1:0]   vld_q  [SETS];
    logic [WAYS-1:0]   lck_q  [SETS];
    logic [WAY_W-1:0]  rr_q   [SETS];

    logic [SET_W-1:0]  set_a;
    logic [TAG_W-1:0]  tag_a;
    logic [WOFF_W-1:0] word_a;
    logic [WOFF_W-1:0] widx;

    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]  hit_vec;
    logic             hit_any;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    int               lock_cnt;

    logic fill_we, lock_we, inv_we;

    assign set_a  = r_q.waddr[WOFF_W +: SET_W];
    assign tag_a  = r_q.waddr[WA_W-1 -: TAG_W];
    assign word_a = r_q.waddr[WOFF_W-1:0];
    assign widx   = word_a + r_q.beat;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w] = tag_q[int'(set_a) * WAYS + w];
        end
    end

    assign lock_cnt = $countones(lck_q[set_a]);

    icache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .set_tags (set_tags),
        .set_vld  (vld_q[set_a]),
        .probe_tag(tag_a),
        .hit_vec  (hit_vec),
        .hit_any  (hit_any),
        .hit_way  (hit_way)
    );

    icache_victim #(.WAYS(WAYS)) i_victim (
        .locked(lck_q[set_a]),
        .ptr   (rr_q[set_a]),
        .victim(victim)
    );

    // next-state logic
    always_comb begin
        r_d        = r_q;
        r_d.f_done = 1'b0;
        r_d.c_err  = 1'b0;
        r_d.m_req  = 1'b0;
        fill_we    = 1'b0;
        lock_we    = 1'b0;
        inv_we     = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (c_inv) begin
                    r_d.st      = ST_INV;
                    r_d.inv_set = '0;
                end else if (c_lock) begin
                    r_d.waddr  = c_waddr;
                    r_d.lockop = 1'b1;
                    r_d.nc     = 1'b0;
                    r_d.st     = ST_LOOK;
                end else if (f_req) begin
                    r_d.waddr  = f_waddr;
                    r_d.lockop = 1'b0;
                    r_d.nc     = f_nc;
                    if (f_nc) begin
                        r_d.m_req = 1'b1;
                        r_d.st    = ST_NCRD;
                    end else begin
                        r_d.st    = ST_LOOK;
                    end
                end
            end
            ST_LOOK: begin
                r_d.st = ST_IDLE;
                if (hit_any) begin
                    if (r_q.lockop) begin
                        if (!lck_q[set_a][hit_way]) begin
                            if (lock_cnt < LOCK_MAX) lock_we = 1'b1;
                            else                     r_d.c_err = 1'b1;
                        end
                    end else begin
                        r_d.f_done = 1'b1;
                        r_d.f_hit  = 1'b1;
                        r_d.f_data = line_q[int'(set_a) * WAYS + int'(hit_way)][int'(word_a) * WORD_W +: WORD_W];
                    end
                end else if (r_q.lockop && lock_cnt >= LOCK_MAX) begin
                    r_d.c_err = 1'b1;
                end else begin
                    r_d.vic   = victim;
                    r_d.beat  = '0;
                    r_d.m_req = 1'b1;
                    r_d.st    = ST_FILL;
                end
            end
            ST_FILL: begin
                if (m_rvalid) begin
                    r_d.lbuf[int'(widx) * WORD_W +: WORD_W] = m_rdata;
                    if (r_q.beat == '0 && !r_q.lockop) begin
                        r_d.f_done = 1'b1;
                        r_d.f_hit  = 1'b0;
                        r_d.f_data = m_rdata;
                    end
                    if (r_q.beat == WOFF_W'(LINE_WORDS - 1)) begin
                        fill_we = 1'b1;
                        r_d.st  = ST_IDLE;
                    end
                    r_d.beat = r_q.beat + WOFF_W'(1);
                end
            end
            ST_NCRD: begin
                if (m_rvalid) begin
                    r_d.f_done = 1'b1;
                    r_d.f_hit  = 1'b0;
                    r_d.f_data = m_rdata;
                    r_d.st     = ST_IDLE;
                end
            end
            ST_INV: begin
                inv_we = 1'b1;
                if (r_q.inv_set == SET_W'(SETS - 1)) r_d.st = ST_IDLE;
                else r_d.inv_set = r_q.inv_set + SET_W'(1);
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // storage arrays
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                lck_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else begin
            if (inv_we) begin
                vld_q[r_q.inv_set] <= '0;
                lck_q[r_q.inv_set] <= '0;
            end
            if (fill_we) begin
                tag_q[int'(set_a) * WAYS + int'(r_q.vic)]  <= tag_a;
                line_q[int'(set_a) * WAYS + int'(r_q.vic)] <= r_d.lbuf;
                vld_q[set_a][r_q.vic] <= 1'b1;
                lck_q[set_a][r_q.vic] <= r_q.lockop;
                rr_q[set_a]           <= r_q.vic + WAY_W'(1);
            end
            if (lock_we) lck_q[set_a][hit_way] <= 1'b1;
        end
    end

    assign f_done   = r_q.f_done;
    assign f_hit    = r_q.f_hit;
    assign f_data   = r_q.f_data;
    assign c_busy   = (r_q.st != ST_IDLE);
    assign c_err    = r_q.c_err;
    assign m_req    = r_q.m_req;
    assign m_single = r_q.nc;
    assign m_waddr  = r_q.waddr;

    // R2: external request is a single-cycle pulse
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req);

    // R3: a miss answer follows a refill or single-word beat
    a_r3_early_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && !f_hit) |-> $past(m_rvalid));

    // R4: a hit answer comes straight from a tag lookup
    a_r4_hit_from_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && f_hit) |-> $past(r_q.st == ST_LOOK));

    // R6: a line lives in at most one way of its set
    a_r6_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK) |-> $onehot0(hit_vec));

    // R7: a fill never overwrites a locked way
    a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !lck_q[set_a][r_q.vic]);

    // R9: the lock limit holds in every set
    for (genvar gs = 0; gs < SETS; gs++) begin : g_cap
        a_r9_lock_cap: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(lck_q[gs]) <= LOCK_MAX);
    end

    // R10: an accepted invalidate makes the block busy
    a_r10_inv_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (c_inv && !c_busy) |=> c_busy);
endmodule

// File: tb/test_icache_lockable.sv
module test_icache_lockable;
    localparam int WAYS   = 4;
    localparam int SETS   = 4;
    localparam int ADDR_W = 32;
    localparam int WA_W   = ADDR_W - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_req = 1'b0, f_nc = 1'b0;
    logic [WA_W-1:0] f_waddr = '0;
    logic f_done, f_hit;
    logic [31:0] f_data;
    logic c_inv = 1'b0, c_lock = 1'b0;
    logic [WA_W-1:0] c_waddr = '0;
    logic c_busy, c_err;
    logic m_req, m_single;
    logic [WA_W-1:0] m_waddr;
    logic m_rvalid;
    logic [31:0] m_rdata;

    int n_tests = 0, n_fail = 0;
    int req_cnt = 0, beats_sent = 0;
    logic last_single;
    logic [WA_W-1:0] last_waddr;

    always #10 clk = ~clk;

    icache_lockable #(.WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W)) i_icache_lockable (
        .clk(clk), .rst_n(rst_n),
        .f_req(f_req), .f_nc(f_nc), .f_waddr(f_waddr),
        .f_done(f_done), .f_hit(f_hit), .f_data(f_data),
        .c_inv(c_inv), .c_lock(c_lock), .c_waddr(c_waddr),
        .c_busy(c_busy), .c_err(c_err),
        .m_req(m_req), .m_single(m_single), .m_waddr(m_waddr),
        .m_rvalid(m_rvalid), .m_rdata(m_rdata)
    );

    function automatic logic [31:0] memw(logic [WA_W-1:0] wa);
        return {wa, 2'b00} ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [WA_W-1:0] wa(int tag, int set, int word);
        return WA_W'((tag << 5) | (set << 3) | word);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // external memory: waits one cycle, then sends beats with a one-cycle gap
    initial begin
        m_rvalid = 1'b0;
        m_rdata  = '0;
        forever begin
            @(negedge clk);
            if (m_req) begin
                logic [WA_W-1:0] base;
                int nb;
                req_cnt++;
                last_single = m_single;
                last_waddr  = m_waddr;
                base = m_waddr;
                nb   = m_single ? 1 : 8;
                @(negedge clk);
                for (int b = 0; b < nb; b++) begin
                    @(negedge clk);
                    m_rvalid = 1'b1;
                    m_rdata  = memw({base[WA_W-1:3], 3'(base[2:0] + 3'(b))});
                    beats_sent++;
                    @(negedge clk);
                    m_rvalid = 1'b0;
                end
            end
        end
    end

    task automatic wait_idle();
        while (c_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fetch(input logic [WA_W-1:0] a, input logic nc,
                         output logic [31:0] d, output logic h, output int cyc, output int bts);
        wait_idle();
        beats_sent = 0;
        f_waddr = a; f_nc = nc; f_req = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!f_done && cyc < 200);
        d = f_data; h = f_hit; bts = beats_sent;
        f_req = 1'b0; f_nc = 1'b0;
        wait_idle();
    endtask

    task automatic lock(input logic [WA_W-1:0] a, output logic err);
        wait_idle();
        c_waddr = a; c_lock = 1'b1;
        @(negedge clk);
        c_lock = 1'b0;
        err = c_err;
        while (c_busy) begin
            @(negedge clk);
            err |= c_err;
        end
        wait_idle();
    endtask

    task automatic inv(output int busy_cyc);
        wait_idle();
        c_inv = 1'b1;
        @(negedge clk);
        c_inv = 1'b0;
        busy_cyc = 0;
        while (c_busy) begin
            busy_cyc++;
            @(negedge clk);
        end
    endtask

    // expect a fetch to hit or miss, checking data
    task automatic expect_fetch(input logic [WA_W-1:0] a, input logic exp_hit, input string req);
        logic [31:0] d; logic h; int c, b, r0;
        r0 = req_cnt;
        fetch(a, 1'b0, d, h, c, b);
        chk(h == exp_hit, req, "hit flag", 32'(h), 32'(exp_hit));
        chk(d == memw(a), req, "fetch data", d, memw(a));
        chk((req_cnt - r0) == (exp_hit ? 0 : 1), req, "memory requests", 32'(req_cnt - r0), exp_hit ? 0 : 1);
    endtask

    task automatic t_reset();
        chk(!c_busy, "R1", "busy after reset", 32'(c_busy), 0);
        chk(!f_done, "R1", "done after reset", 32'(f_done), 0);
        chk(!m_req && !c_err, "R1", "req/err after reset", 32'({m_req, c_err}), 0);
    endtask

    task automatic t_miss();
        logic [31:0] d; logic h; int c, b, r0;
        logic [WA_W-1:0] a;
        a  = wa(5, 1, 3);
        r0 = req_cnt;
        fetch(a, 1'b0, d, h, c, b);
        chk(req_cnt - r0 == 1, "R2", "one line read on cold miss", 32'(req_cnt - r0), 1);
        chk(last_single == 1'b0, "R2", "line read not single", 32'(last_single), 0);
        chk(last_waddr == a, "R2", "critical word address", 32'(last_waddr), 32'(a));
        chk(h == 1'b0 && d == memw(a), "R3", "miss answer data", d, memw(a));
        chk(b == 1, "R3", "beats seen at answer", 32'(b), 1);
    endtask

    task automatic t_hit();
        logic [31:0] d; logic h; int c, b, r0;
        r0 = req_cnt;
        fetch(wa(5, 1, 6), 1'b0, d, h, c, b);
        chk(h && d == memw(wa(5, 1, 6)), "R4", "hit data", d, memw(wa(5, 1, 6)));
        chk(c == 2, "R4", "hit latency", 32'(c), 2);
        chk(req_cnt == r0, "R4", "no request on hit", 32'(req_cnt - r0), 0);
        expect_fetch(wa(5, 1, 0), 1'b1, "R2");
    endtask

    task automatic t_nc();
        logic [31:0] d; logic h; int c, b, r0;
        r0 = req_cnt;
        fetch(wa(9, 2, 1), 1'b1, d, h, c, b);
        chk(last_single == 1'b1, "R5", "single-word read", 32'(last_single), 1);
        chk(!h && d == memw(wa(9, 2, 1)), "R5", "non-cacheable data", d, memw(wa(9, 2, 1)));
        chk(req_cnt - r0 == 1, "R5", "one request", 32'(req_cnt - r0), 1);
        expect_fetch(wa(9, 2, 1), 1'b0, "R5");
    endtask

    task automatic t_rr();
        int bc;
        inv(bc);
        for (int t = 20; t < 25; t++) expect_fetch(wa(t, 3, 0), 1'b0, "R6");
        expect_fetch(wa(21, 3, 2), 1'b1, "R6");
        expect_fetch(wa(20, 3, 2), 1'b0, "R6");
        expect_fetch(wa(21, 3, 2), 1'b0, "R6");
        expect_fetch(wa(23, 3, 4), 1'b1, "R6");
    endtask

    task automatic t_lock();
        logic e; int bc, r0;
        inv(bc);
        r0 = req_cnt;
        lock(wa(30, 0, 2), e);
        chk(!e && req_cnt - r0 == 1, "R8", "lock of absent line loads it", 32'(req_cnt - r0), 1);
        chk(last_single == 1'b0, "R8", "lock load is a line read", 32'(last_single), 0);
        expect_fetch(wa(30, 0, 5), 1'b1, "R8");
        r0 = req_cnt;
        lock(wa(30, 0, 1), e);
        chk(!e && req_cnt == r0, "R8", "relock is a no-op", 32'(req_cnt - r0), 0);
        for (int t = 40; t < 46; t++) expect_fetch(wa(t, 0, 0), 1'b0, "R7");
        expect_fetch(wa(30, 0, 7), 1'b1, "R7");
        expect_fetch(wa(50, 1, 0), 1'b0, "R8");
        r0 = req_cnt;
        lock(wa(50, 1, 3), e);
        chk(!e && req_cnt == r0, "R8", "lock in place no read", 32'(req_cnt - r0), 0);
        for (int t = 51; t < 57; t++) expect_fetch(wa(t, 1, 0), 1'b0, "R7");
        expect_fetch(wa(50, 1, 6), 1'b1, "R7");
    endtask

    task automatic t_cap();
        logic e; int bc, r0;
        inv(bc);
        for (int t = 60; t < 63; t++) begin
            lock(wa(t, 2, 0), e);
            chk(!e, "R9", "lock within limit", 32'(e), 0);
        end
        r0 = req_cnt;
        lock(wa(63, 2, 0), e);
        chk(e, "R9", "lock beyond limit refused", 32'(e), 1);
        chk(req_cnt == r0, "R9", "no read on refusal", 32'(req_cnt - r0), 0);
        expect_fetch(wa(63, 2, 1), 1'b0, "R9");
        expect_fetch(wa(64, 2, 1), 1'b0, "R9");
        lock(wa(64, 2, 1), e);
        chk(e, "R9", "lock of present line beyond limit", 32'(e), 1);
        expect_fetch(wa(65, 2, 0), 1'b0, "R9");
        expect_fetch(wa(64, 2, 0), 1'b0, "R9");
        expect_fetch(wa(61, 2, 3), 1'b1, "R7");
    endtask

    task automatic t_inv();
        logic e; int bc;
        inv(bc);
        chk(bc == SETS, "R10", "busy cycles of invalidate", 32'(bc), SETS);
        expect_fetch(wa(60, 2, 0), 1'b0, "R10");
        for (int t = 70; t < 73; t++) begin
            lock(wa(t, 2, 0), e);
            chk(!e, "R10", "locks cleared by invalidate", 32'(e), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss();
        t_hit();
        t_nc();
        t_rr();
        t_lock();
        t_cap();
        t_inv();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule